// File: doc/BRIEF.md
# Dual-Channel Wiper Register Target on I2C

This block is the serial front end of a dual 256-step digital potentiometer. It is an I2C target that watches SCL and SDA on the system clock, recognises start and stop, and answers its own 7-bit address. Five of the address bits are fixed by a parameter and the two low bits come from strap pins, so up to four such devices can share one bus. It holds one 8-bit wiper code and one shutdown flag for each of the two channels. The analog ladder that uses these values is not part of the block.

In a write transaction the byte after the address is an instruction. It picks the channel and sets or clears that channel's shutdown flag. Every data byte that follows in the same transaction overwrites the picked channel's wiper code. A read transaction carries no instruction. It returns the wiper code of the channel picked by the most recent instruction, and goes on returning it for as long as the controller keeps acknowledging. SDA is only ever pulled low, through an open-drain enable.

Top module: `dpot_i2c_target`

## Requirements
- R1: After reset both wiper codes read 0x80, both shutdown flags are 0, SDA is released (sda_oe_o = 0), and channel 1 (index 0) is the selected channel.
- R2: A start (SDA falling while SCL is high) restarts address reception from any state and throws away any partly received byte. After a stop (SDA rising while SCL is high) the block acknowledges nothing and changes nothing until the next start.
- R3: The first byte after a start holds the address in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). When bits 7:1 equal {ADDR_HI, strap_i}, the block drives SDA low for the whole ninth clock as acknowledge. On any other value it does not acknowledge, and the rest of that transaction has no effect on any output.
- R4: In a write, the byte after the address is the instruction. Bit 7 selects the channel (0 = wiper0_o, 1 = wiper1_o). Bit 6 becomes that channel's shutdown flag. Bits 5:0 have no effect. The instruction takes effect when it is acknowledged, even if no data byte follows, and it leaves both wiper codes unchanged.
- R5: Each data byte that follows the instruction in the same write transaction is acknowledged and replaces the selected channel's wiper code. The other channel's code is left as it was.
- R6: Shutdown does not destroy the stored value. While its flag is set, a channel's wiper output keeps its stored code and can still be written and read back. Clearing the flag leaves the stored code in place.
- R7: In a read, the selected channel's code is sent MSB first. The first bit is on SDA once the address acknowledge ends. Each byte the controller acknowledges is followed by the same code again. After a NACK the block releases SDA and ignores further clocks until the next start or stop.
- R8: The strap inputs are sampled continuously. A change on strap_i moves the address the block answers to for the next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Low two address bits from strap pins |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| wiper0_o | output | 8 | Stored code of channel 1 |
| wiper1_o | output | 8 | Stored code of channel 2 |
| shdn_o | output | 2 | Shutdown flag per channel (bit 0 = channel 1) |

## Verification
Assertions check on every cycle that:
- a start puts the block into address reception with SDA released, and a stop returns it to idle with SDA released;
- the SDA enable changes only just after a falling SCL edge;
- instruction and data commits never happen together;
- a wiper code or shutdown flag never changes without its own commit pulse.

Only the bench scenarios can show that the address comparison acknowledges exactly one of the 128 addresses, and that the repeated-write path carries each of the 256 codes. They also show three more things:
- reads return the channel picked by the last instruction, even while that channel is shut down;
- a NACK or an unmatched address silences the block;
- a repeated start in the middle of a byte discards that byte.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DW     = 8;            // bits per wiper code and per bus byte
  localparam int NCH    = 2;            // wiper channels
  localparam int SEL_W  = $clog2(NCH);  // channel select width
  localparam int CH_BIT = 7;            // instruction: channel select position
  localparam int SD_BIT = 6;            // instruction: shutdown flag position
  localparam int CNT_W  = 4;            // counts 0..9 clock edges per byte

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
  parameter int          W    = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      q_o    <= INIT;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dpot_bus_fsm.sv
module dpot_bus_fsm
  import dpot_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic [1:0]    strap,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe_o,
  output logic          wr_instr_o,
  output logic          wr_data_o,
  output logic [DW-1:0] byte_o
);
  bus_state_e       state;
  logic             scl_p, sda_p;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    shreg, txreg;
  logic             rw_q;
  logic             scl_rise, scl_fall, start_c, stop_c;
  logic [6:0]       my_addr;

  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DW + 1);

  assign scl_rise = scl & ~scl_p;
  assign scl_fall = ~scl & scl_p;
  assign start_c  = scl & scl_p & sda_p & ~sda;
  assign stop_c   = scl & scl_p & ~sda_p & sda;
  assign my_addr  = {ADDR_HI, strap};
  assign byte_o   = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      txreg      <= '0;
      rw_q       <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_instr_o <= 1'b0;
      wr_data_o  <= 1'b0;
    end else begin
      wr_instr_o <= 1'b0;
      wr_data_o  <= 1'b0;
      if (start_c) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (scl_rise && cnt < BYTE_END) begin
              shreg <= {shreg[DW-2:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_END) begin
              if (state == ST_ADDR) begin
                if (shreg[DW-1:1] == my_addr) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= shreg[0];
                  cnt      <= ACK_SLOT;
                end else begin
                  state <= ST_SKIP;
                  cnt   <= '0;
                end
              end else begin
                sda_oe_o   <= 1'b1;
                cnt        <= ACK_SLOT;
                wr_instr_o <= (state == ST_INSTR);
                wr_data_o  <= (state == ST_WDATA);
              end
            end else if (scl_fall && cnt == ACK_SLOT) begin
              cnt      <= '0;
              sda_oe_o <= 1'b0;
              if (state == ST_ADDR) begin
                if (rw_q) begin
                  state    <= ST_RDATA;
                  txreg    <= rd_data;
                  sda_oe_o <= ~rd_data[DW-1];
                end else begin
                  state <= ST_INSTR;
                end
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && cnt < BYTE_END) begin
              cnt <= cnt + 1'b1;
            end else if (scl_rise && cnt == BYTE_END) begin
              if (sda) begin
                state <= ST_SKIP;
                cnt   <= '0;
              end else begin
                cnt <= ACK_SLOT;
              end
            end else if (scl_fall && cnt != '0 && cnt < BYTE_END) begin
              txreg    <= {txreg[DW-2:0], 1'b0};
              sda_oe_o <= ~txreg[DW-2];
            end else if (scl_fall && cnt == BYTE_END) begin
              sda_oe_o <= 1'b0;
            end else if (scl_fall && cnt == ACK_SLOT) begin
              cnt      <= '0;
              txreg    <= rd_data;
              sda_oe_o <= ~rd_data[DW-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_start_enters_addr: assert property (@(posedge clk) disable iff (rst)
    start_c |=> (state == ST_ADDR && !sda_oe_o));
  a_r2_stop_goes_idle: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> (state == ST_IDLE && !sda_oe_o));
  a_r3_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe_o);
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> $past(scl_fall));
  a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_instr_o, wr_data_o}));
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank
  import dpot_pkg::*;
#(
  parameter logic [DW-1:0] PRESET = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_instr_i,
  input  logic                   wr_data_i,
  input  logic [DW-1:0]          byte_i,
  output logic [NCH-1:0][DW-1:0] wipers_o,
  output logic [NCH-1:0]         shdn_o,
  output logic [DW-1:0]          rd_data_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)             sel_q <= '0;
    else if (wr_instr_i) sel_q <= byte_i[CH_BIT -: SEL_W];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] code_q;
    logic          sd_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= PRESET;
        sd_q   <= 1'b0;
      end else begin
        if (wr_data_i && sel_q == SEL_W'(g))
          code_q <= byte_i;
        if (wr_instr_i && byte_i[CH_BIT -: SEL_W] == SEL_W'(g))
          sd_q <= byte_i[SD_BIT];
      end
    end
    assign wipers_o[g] = code_q;
    assign shdn_o[g]   = sd_q;
  end

  assign rd_data_o = wipers_o[sel_q];

  a_r1_preset_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wipers_o == {NCH{PRESET}} && shdn_o == '0));
  a_r6_code_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_data_i |=> $stable(wipers_o));
  a_r4_shdn_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_instr_i |=> $stable(shdn_o));
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
  import dpot_pkg::*;
#(
  parameter logic [4:0]    ADDR_HI = 5'b01011,
  parameter logic [DW-1:0] PRESET  = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] wiper0_o,
  output logic [DW-1:0] wiper1_o,
  output logic [1:0]    shdn_o
);
  logic [3:0]             sync_q;
  logic                   wr_instr, wr_data;
  logic [DW-1:0]          bus_byte, rd_data;
  logic [NCH-1:0][DW-1:0] wipers;

  dpot_line_sync #(.W(4), .INIT(4'b1111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({strap_i, sda_i, scl_i}),
    .q_o (sync_q)
  );

  dpot_bus_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl        (sync_q[0]),
    .sda        (sync_q[1]),
    .strap      (sync_q[3:2]),
    .rd_data    (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_instr_o (wr_instr),
    .wr_data_o  (wr_data),
    .byte_o     (bus_byte)
  );

  dpot_wiper_bank #(.PRESET(PRESET)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_instr_i (wr_instr),
    .wr_data_i  (wr_data),
    .byte_i     (bus_byte),
    .wipers_o   (wipers),
    .shdn_o     (shdn_o),
    .rd_data_o  (rd_data)
  );

  assign wiper0_o = wipers[0];
  assign wiper1_o = wipers[1];
endmodule

// File: tb/dpot_i2c_target_tb.sv
module dpot_i2c_target_tb;
  localparam int         Q  = 5;
  localparam logic [4:0] AH = 5'b01011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic [7:0] w0, w1;
  logic [1:0] shdn;
  logic sda_bus;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  dpot_i2c_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .wiper0_o(w0), .wiper1_o(w1), .shdn_o(shdn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; qw(); scl_drv = 1'b1; qw();
    sda_drv = 1'b0; qw(); scl_drv = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qw(); scl_drv = 1'b1; qw();
    sda_drv = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; qw(); scl_drv = 1'b1; qw(); qw(); scl_drv = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; qw(); scl_drv = 1'b1; qw(); b = sda_bus; qw();
    scl_drv = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(x);
    ack = ~x;
  endtask

  task automatic read_byte(output logic [7:0] v, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      v[i] = x;
    end
    send_bit(~give_ack);
  endtask

  // Full write: address, instruction, optional data bytes
  task automatic wr_txn(input logic [7:0] instr, input int ndata, input logic [7:0] d);
    logic ack;
    bus_start();
    write_byte({AH, strap, 1'b0}, ack);
    chk("R3 write address ack", ack, 1);
    write_byte(instr, ack);
    chk("R4 instruction ack", ack, 1);
    for (int k = 0; k < ndata; k++) begin
      write_byte(d, ack);
      chk("R5 data ack", ack, 1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rv;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset wiper0", w0, 8'h80);
    chk("R1 reset wiper1", w1, 8'h80);
    chk("R1 reset shutdown", shdn, 0);
    chk("R1 reset sda released", sda_oe, 0);

    // R1: read right after reset returns channel 1 preset
    bus_start();
    write_byte({AH, strap, 1'b1}, ack);
    chk("R1 read address ack", ack, 1);
    read_byte(rv, 1'b0);
    chk("R1 reset read value", rv, 8'h80);
    bus_stop();

    // R3: sweep of all 7-bit addresses, mismatches followed by ignored bytes
    for (int a = 0; a < 128; a++) begin
      bus_start();
      write_byte({a[6:0], 1'b0}, ack);
      chk("R3 address sweep ack", ack, (a[6:0] == {AH, strap}) ? 1 : 0);
      if (a[6:0] != {AH, strap}) begin
        write_byte(8'hC0, ack);
        write_byte(8'h11, ack);
        chk("R3 mismatch ignored bytes not acked", ack, 0);
      end
      bus_stop();
      if (a[6:0] != {AH, strap}) begin
        chk("R3 mismatch wiper1 unchanged", w1, 8'h80);
        chk("R3 mismatch shutdown unchanged", shdn, 0);
      end
    end

    // R8: strap change moves the address
    strap = 2'b01;
    repeat (10) @(negedge clk);
    bus_start();
    write_byte({AH, 2'b10, 1'b0}, ack);
    chk("R8 old strap address not acked", ack, 0);
    bus_stop();
    bus_start();
    write_byte({AH, 2'b01, 1'b0}, ack);
    chk("R8 new strap address acked", ack, 1);
    bus_stop();

    // R4: instruction only, channel 2 shutdown
    wr_txn(8'hC0, 0, 8'h00);
    chk("R4 instr-only shutdown ch2", shdn, 2'b10);
    chk("R4 instr-only wiper1 kept", w1, 8'h80);
    chk("R4 instr-only wiper0 kept", w0, 8'h80);

    // R6: write while shut down
    wr_txn(8'hC0, 1, 8'h3C);
    chk("R6 write during shutdown", w1, 8'h3C);
    chk("R6 shutdown still set", shdn, 2'b10);
    bus_start();
    write_byte({AH, strap, 1'b1}, ack);
    read_byte(rv, 1'b0);
    bus_stop();
    chk("R6 readback during shutdown", rv, 8'h3C);
    wr_txn(8'h80, 0, 8'h00);
    chk("R6 shutdown cleared", shdn, 0);
    chk("R6 value kept after clearing", w1, 8'h3C);

    // R4: low six instruction bits ignored
    wr_txn(8'h3F, 1, 8'h21);
    chk("R4 low bits ignored wiper0", w0, 8'h21);
    chk("R4 low bits ignored wiper1", w1, 8'h3C);
    chk("R4 low bits ignored shutdown", shdn, 0);
    wr_txn(8'h7F, 0, 8'h00);
    chk("R4 shutdown ch1", shdn, 2'b01);
    wr_txn(8'h00, 0, 8'h00);
    chk("R4 shutdown ch1 cleared", shdn, 0);

    // R5: repeated write of every code
    bus_start();
    write_byte({AH, strap, 1'b0}, ack);
    write_byte(8'h00, ack);
    for (int v = 0; v < 256; v++) begin
      write_byte(v[7:0], ack);
      chk("R5 repeated write ack", ack, 1);
      chk("R5 repeated write value", w0, v);
    end
    bus_stop();
    chk("R5 other channel untouched", w1, 8'h3C);

    // R7: repeated reads, then NACK silences the target
    wr_txn(8'h00, 1, 8'hA5);
    bus_start();
    write_byte({AH, strap, 1'b1}, ack);
    chk("R7 read address ack", ack, 1);
    read_byte(rv, 1'b1); chk("R7 read byte 1", rv, 8'hA5);
    read_byte(rv, 1'b1); chk("R7 read byte 2", rv, 8'hA5);
    read_byte(rv, 1'b0); chk("R7 read byte 3", rv, 8'hA5);
    read_byte(rv, 1'b0); chk("R7 released after nack", rv, 8'hFF);
    bus_stop();

    // R7: selection is sticky across transactions
    wr_txn(8'h80, 0, 8'h00);
    chk("R7 instr-only keeps wiper0", w0, 8'hA5);
    bus_start();
    write_byte({AH, strap, 1'b1}, ack);
    read_byte(rv, 1'b0);
    bus_stop();
    chk("R7 read follows last selection", rv, 8'h3C);

    // R2: repeated start inside a data byte discards it
    bus_start();
    write_byte({AH, strap, 1'b0}, ack);
    write_byte(8'h80, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    write_byte({AH, strap, 1'b0}, ack);
    chk("R2 repeated start address ack", ack, 1);
    write_byte(8'h00, ack);
    write_byte(8'h42, ack);
    bus_stop();
    chk("R2 after restart wiper0", w0, 8'h42);
    chk("R2 partial byte discarded wiper1", w1, 8'h3C);

    // R2: stop mid-instruction, then bytes without start are ignored
    bus_start();
    write_byte({AH, strap, 1'b0}, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    sda_drv = 1'b1; qw(); scl_drv = 1'b0; qw();
    write_byte({AH, strap, 1'b0}, ack);
    chk("R2 no ack without start", ack, 0);
    bus_stop();
    chk("R2 shutdown unchanged after stop", shdn, 0);
    chk("R2 wiper0 unchanged after stop", w0, 8'h42);
    chk("R2 sda released after stop", sda_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule